// File: doc/BRIEF.md
# Multi-mode effective address unit

This unit resolves the operand of an accumulator-style instruction. A request carries a 3-bit addressing mode, an address/operand field and an explicit register number. The unit drives a register-file read port and a synchronous memory read port and, after a mode-dependent number of cycles, returns the final operand together with an illegal-mode flag. A load-accumulator path can take the result directly.

Requests and results both use valid/ready handshakes. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the unit is idle, so one request is in flight at a time. A result is offered with `res_valid` and is held unchanged until the consumer raises `res_ready`; the unit takes no new request before then. The register file is read combinationally within one cycle. Memory returns data one cycle after `mem_rd` is high.

Top module: `ea_unit`

## Requirements
- R1: After reset, `req_ready` is 1, `res_valid` is 0 and `mem_rd` is 0.
- R2: Mode 0 (immediate) returns the field sign-extended to the data width. It issues no memory read. The result is valid 1 cycle after the accepting edge.
- R3: Mode 1 (register) returns the contents of the register numbered by the low register-index bits of the field. It issues no memory read. The result is valid after 1 cycle.
- R4: Mode 2 (direct) returns memory at the field address. It issues one read, and the result is valid after 2 cycles.
- R5: Mode 3 (register indirect) returns memory at the address held in the low address-width bits of the register numbered by the field. It issues one read, and the result is valid after 2 cycles.
- R6: Mode 4 (memory indirect) reads memory at the field address. It uses the low address-width bits of that word as a second address and returns memory there. It issues two reads, and the result is valid after 3 cycles.
- R7: Mode 5 (indexed) returns memory at field plus the low bits of the fixed index register (register 7 by default), wrapping modulo 2^address-width. It issues one read, and the result is valid after 2 cycles.
- R8: Mode 6 (based) returns memory at the low bits of the register named by `req_breg` plus the field as displacement, wrapping modulo 2^address-width. It issues one read, and the result is valid after 2 cycles.
- R9: Mode 7 returns `res_illegal` = 1 with operand 0 after 1 cycle and issues no memory read. All other modes return `res_illegal` = 0.
- R10: While `res_valid` is high and `res_ready` is low, `res_operand` and `res_illegal` stay stable and `req_ready` stays 0.
- R11: Every `mem_rd` pulse is followed by a cycle in which the unit consumes read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_mode | input | 3 | Addressing mode code |
| req_field | input | AW | Address / immediate / displacement field |
| req_breg | input | RW | Base register number (based mode) |
| res_valid | output | 1 | Result offered |
| res_ready | input | 1 | Consumer takes the result |
| res_operand | output | DW | Resolved operand |
| res_illegal | output | 1 | Mode code 7 was requested |
| rf_raddr | output | RW | Register-file read index |
| rf_rdata | input | DW | Register-file read data, same cycle |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | DW | Memory data, one cycle after `mem_rd` |

## Verification
The operand of an immediate, register or illegal request is due 1 cycle after the accepting edge. A single-read mode is due after 2 cycles, and memory indirect after 3. The driver records the number of the accepting edge with each expected item. The monitor samples on falling clock edges, measures the cycle distance to the first `res_valid`, and also counts `mem_rd` pulses seen during the transaction. Operand, flag, latency and read count are all compared against the queued item. A back-pressure case holds `res_ready` low for several cycles and checks that the result stays stable.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [2:0] {
    MODE_IMM  = 3'd0,
    MODE_REG  = 3'd1,
    MODE_DIR  = 3'd2,
    MODE_RIND = 3'd3,
    MODE_MIND = 3'd4,
    MODE_IDX  = 3'd5,
    MODE_BASE = 3'd6,
    MODE_BAD  = 3'd7
  } ea_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CALC  = 3'd1,
    ST_READ1 = 3'd2,
    ST_READ2 = 3'd3,
    ST_DONE  = 3'd4
  } ea_state_e;

endpackage

// File: rtl/ea_reg_sel.sv
module ea_reg_sel
  import ea_pkg::*;
#(
  parameter int RW = 3,
  parameter logic [RW-1:0] IDX_SEL = '1
) (
  input  ea_mode_e        mode,
  input  logic [RW-1:0]   field_idx,
  input  logic [RW-1:0]   breg,
  output logic [RW-1:0]   rf_raddr
);

  // Indexed mode reads an implicit register, based mode an explicit one,
  // every other mode takes the register number from the field.
  always_comb begin
    unique case (mode)
      MODE_IDX:  rf_raddr = IDX_SEL;
      MODE_BASE: rf_raddr = breg;
      default:   rf_raddr = field_idx;
    endcase
  end

endmodule

// File: rtl/ea_addr_gen.sv
module ea_addr_gen
  import ea_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  ea_mode_e        mode,
  input  logic [AW-1:0]   field,
  input  logic [AW-1:0]   reg_addr,
  output logic [AW-1:0]   first_addr,
  output logic [DW-1:0]   imm_val
);

  logic [AW-1:0] sum;

  // AW-bit adder: carry out is discarded so the address wraps
  assign sum = field + reg_addr;

  always_comb begin
    unique case (mode)
      MODE_RIND:          first_addr = reg_addr;
      MODE_IDX, MODE_BASE: first_addr = sum;
      default:            first_addr = field;
    endcase
  end

  generate
    if (DW > AW) begin : g_sext
      assign imm_val = {{(DW-AW){field[AW-1]}}, field};
    end else begin : g_trunc
      assign imm_val = field[DW-1:0];
    end
  endgenerate

endmodule

// File: rtl/ea_seq.sv
module ea_seq
  import ea_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int RW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [2:0]      req_mode,
  input  logic [AW-1:0]   req_field,
  input  logic [RW-1:0]   req_breg,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [DW-1:0]   res_operand,
  output logic            res_illegal,
  output logic            mem_rd,
  output logic [AW-1:0]   mem_addr,
  input  logic [DW-1:0]   mem_rdata,
  output ea_mode_e        cur_mode,
  output logic [AW-1:0]   cur_field,
  output logic [RW-1:0]   cur_breg,
  input  logic [AW-1:0]   first_addr,
  input  logic [DW-1:0]   imm_val,
  input  logic [DW-1:0]   rf_rdata
);

  ea_state_e     state, state_n;
  ea_mode_e      mode_q;
  logic [AW-1:0] field_q;
  logic [RW-1:0] breg_q;
  logic [DW-1:0] result_q, res_next;
  logic          illegal_q;
  logic          load_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      mode_q    <= MODE_IMM;
      field_q   <= '0;
      breg_q    <= '0;
      result_q  <= '0;
      illegal_q <= 1'b0;
    end else begin
      state <= state_n;
      if (state == ST_IDLE && req_valid) begin
        mode_q    <= ea_mode_e'(req_mode);
        field_q   <= req_field;
        breg_q    <= req_breg;
        illegal_q <= 1'b0;
      end
      if (state == ST_CALC && mode_q == MODE_BAD) illegal_q <= 1'b1;
      if (load_res) result_q <= res_next;
    end
  end

  always_comb begin
    state_n  = state;
    load_res = 1'b0;
    res_next = mem_rdata;
    mem_rd   = 1'b0;
    mem_addr = first_addr;
    unique case (state)
      ST_IDLE: if (req_valid) state_n = ST_CALC;
      ST_CALC: begin
        unique case (mode_q)
          MODE_IMM: begin load_res = 1'b1; res_next = imm_val;  state_n = ST_DONE; end
          MODE_REG: begin load_res = 1'b1; res_next = rf_rdata; state_n = ST_DONE; end
          MODE_BAD: begin load_res = 1'b1; res_next = '0;       state_n = ST_DONE; end
          default:  begin mem_rd = 1'b1; state_n = ST_READ1; end
        endcase
      end
      ST_READ1: begin
        if (mode_q == MODE_MIND) begin
          mem_rd   = 1'b1;
          mem_addr = mem_rdata[AW-1:0];
          state_n  = ST_READ2;
        end else begin
          load_res = 1'b1;
          state_n  = ST_DONE;
        end
      end
      ST_READ2: begin load_res = 1'b1; state_n = ST_DONE; end
      ST_DONE:  if (res_ready) state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  assign req_ready   = (state == ST_IDLE);
  assign res_valid   = (state == ST_DONE);
  assign res_operand = result_q;
  assign res_illegal = illegal_q;
  assign cur_mode    = mode_q;
  assign cur_field   = field_q;
  assign cur_breg    = breg_q;

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_operand) && $stable(res_illegal));

  // R10
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);

  // R11
  read_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (state == ST_READ1 || state == ST_READ2));

  // R9
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_illegal |-> res_operand == '0);

endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int AW      = 8,
  parameter int DW      = 16,
  parameter int RW      = 3,
  parameter int IDX_REG = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [2:0]      req_mode,
  input  logic [AW-1:0]   req_field,
  input  logic [RW-1:0]   req_breg,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [DW-1:0]   res_operand,
  output logic            res_illegal,
  output logic [RW-1:0]   rf_raddr,
  input  logic [DW-1:0]   rf_rdata,
  output logic            mem_rd,
  output logic [AW-1:0]   mem_addr,
  input  logic [DW-1:0]   mem_rdata
);

  localparam logic [RW-1:0] IDX_SEL = RW'(IDX_REG);

  ea_mode_e      cur_mode;
  logic [AW-1:0] cur_field;
  logic [RW-1:0] cur_breg;
  logic [AW-1:0] first_addr;
  logic [DW-1:0] imm_val;

  ea_reg_sel #(.RW(RW), .IDX_SEL(IDX_SEL)) u_rsel (
    .mode      (cur_mode),
    .field_idx (cur_field[RW-1:0]),
    .breg      (cur_breg),
    .rf_raddr  (rf_raddr)
  );

  ea_addr_gen #(.AW(AW), .DW(DW)) u_agen (
    .mode       (cur_mode),
    .field      (cur_field),
    .reg_addr   (rf_rdata[AW-1:0]),
    .first_addr (first_addr),
    .imm_val    (imm_val)
  );

  ea_seq #(.AW(AW), .DW(DW), .RW(RW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_mode    (req_mode),
    .req_field   (req_field),
    .req_breg    (req_breg),
    .res_valid   (res_valid),
    .res_ready   (res_ready),
    .res_operand (res_operand),
    .res_illegal (res_illegal),
    .mem_rd      (mem_rd),
    .mem_addr    (mem_addr),
    .mem_rdata   (mem_rdata),
    .cur_mode    (cur_mode),
    .cur_field   (cur_field),
    .cur_breg    (cur_breg),
    .first_addr  (first_addr),
    .imm_val     (imm_val),
    .rf_rdata    (rf_rdata)
  );

endmodule

// File: tb/tb_ea_unit.sv
module tb_ea_unit;

  typedef struct {
    string       tag;
    logic [15:0] op;
    logic        ill;
    int          lat;
    int          rds;
    int          acc;
  } item_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [2:0]  req_mode = 0;
  logic [7:0]  req_field = 0;
  logic [2:0]  req_breg = 0;
  logic        res_valid;
  logic        res_ready = 1;
  logic [15:0] res_operand;
  logic        res_illegal;
  logic [2:0]  rf_raddr;
  logic [15:0] rf_rdata;
  logic        mem_rd;
  logic [7:0]  mem_addr;
  logic [15:0] mem_rdata = 0;

  logic [15:0] rf_m [8];
  logic [15:0] mem_m [256];

  int checks = 0, fails = 0, cyc = 0;
  int rd_cnt = 0, lat_seen = 0;
  bit seen = 0;
  bit finished = 0;
  item_t q[$];

  always #5 clk = ~clk;

  ea_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_field(req_field), .req_breg(req_breg),
    .res_valid(res_valid), .res_ready(res_ready), .res_operand(res_operand),
    .res_illegal(res_illegal), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  assign rf_rdata = rf_m[rf_raddr];
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd) mem_rdata <= mem_m[mem_addr];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Reference model built from the requirements
  task automatic model(input logic [2:0] m, input logic [7:0] f, input logic [2:0] b,
                       output item_t it);
    logic [7:0] a;
    it.ill = 0; it.lat = 2; it.rds = 1;
    case (m)
      3'd0: begin it.tag = "R2"; it.op = {{8{f[7]}}, f}; it.lat = 1; it.rds = 0; end
      3'd1: begin it.tag = "R3"; it.op = rf_m[f[2:0]]; it.lat = 1; it.rds = 0; end
      3'd2: begin it.tag = "R4"; it.op = mem_m[f]; end
      3'd3: begin it.tag = "R5"; it.op = mem_m[rf_m[f[2:0]][7:0]]; end
      3'd4: begin it.tag = "R6"; it.op = mem_m[mem_m[f][7:0]]; it.lat = 3; it.rds = 2; end
      3'd5: begin it.tag = "R7"; a = f + rf_m[7][7:0]; it.op = mem_m[a]; end
      3'd6: begin it.tag = "R8"; a = rf_m[b][7:0] + f; it.op = mem_m[a]; end
      default: begin it.tag = "R9"; it.op = 16'h0; it.ill = 1; it.lat = 1; it.rds = 0; end
    endcase
  endtask

  // Driver: queue expected item, then present request until accepted
  task automatic send(input logic [2:0] m, input logic [7:0] f, input logic [2:0] b);
    item_t it;
    model(m, f, b, it);
    @(negedge clk);
    req_mode = m; req_field = f; req_breg = b; req_valid = 1;
    while (!req_ready) @(negedge clk);
    it.acc = cyc + 1;
    q.push_back(it);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  // Monitor: compares results against the queued expectations
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (mem_rd) rd_cnt++;
      if (res_valid && !seen && q.size() != 0) begin
        seen = 1;
        lat_seen = cyc - q[0].acc;
      end
      if (res_valid && res_ready) begin
        if (q.size() == 0) begin
          chk("R10 unexpected result", 1, 0);
        end else begin
          item_t it;
          it = q.pop_front();
          chk({it.tag, " operand"}, res_operand, it.op);
          chk({it.tag, " R9 illegal flag"}, res_illegal, it.ill);
          chk({it.tag, " latency"}, lat_seen, it.lat);
          chk({it.tag, " R11 read count"}, rd_cnt, it.rds);
          chk({it.tag, " R10 busy req_ready"}, req_ready, 0);
        end
        seen = 0;
        rd_cnt = 0;
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem_m[i] = 16'(i * 16'h0107 + 16'h0013);
    mem_m[8'h20] = 16'hAB40;     // pointer: low byte 0x40
    mem_m[8'h40] = 16'hBEEF;
    mem_m[8'hF0] = 16'h00F7;     // pointer near the top
    mem_m[8'hF7] = 16'h5A5A;
    rf_m[0] = 16'h0000; rf_m[1] = 16'h0030; rf_m[2] = 16'h12F0; rf_m[3] = 16'h8001;
    rf_m[4] = 16'h7FFF; rf_m[5] = 16'hC0DE; rf_m[6] = 16'h00FF; rf_m[7] = 16'h0005;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 req_ready", req_ready, 1);
    chk("R1 res_valid", res_valid, 0);
    chk("R1 mem_rd", mem_rd, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 req_ready after release", req_ready, 1);

    send(3'd0, 8'h7F, 0); drain();   // R2 positive
    send(3'd0, 8'h80, 0); drain();   // R2 negative extends
    send(3'd1, 8'h05, 0); drain();   // R3
    send(3'd1, 8'hFB, 0); drain();   // R3 uses low index bits (reg 3)
    send(3'd2, 8'h40, 0); drain();   // R4
    send(3'd2, 8'hFF, 0); drain();   // R4 top address
    send(3'd3, 8'h01, 0); drain();   // R5 via reg1 = 0x30
    send(3'd3, 8'h02, 0); drain();   // R5 upper register bits ignored
    send(3'd4, 8'h20, 0); drain();   // R6 chain 0x20 -> 0x40
    send(3'd4, 8'hF0, 0); drain();   // R6 chain 0xF0 -> 0xF7
    send(3'd5, 8'h10, 0); drain();   // R7
    send(3'd5, 8'hFE, 0); drain();   // R7 wraps to 0x03
    send(3'd6, 8'h20, 3'd2); drain(); // R8 0xF0 + 0x20 wraps to 0x10
    send(3'd6, 8'h01, 3'd1); drain(); // R8
    send(3'd7, 8'h44, 0); drain();   // R9
    send(3'd2, 8'h40, 0); drain();   // R9 flag clears on next request

    // R10 back-pressure: result must hold while res_ready is low
    res_ready = 0;
    send(3'd4, 8'h20, 0);
    repeat (6) @(negedge clk);
    chk("R10 valid held", res_valid, 1);
    chk("R10 operand held", res_operand, 16'hBEEF);
    chk("R10 req_ready low while held", req_ready, 0);
    res_ready = 1;
    drain();
    send(3'd0, 8'h01, 0); drain();

    finished = 1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired: actual=hung expected=complete");
      summary();
    end
  end

endmodule